// File: doc/BRIEF.md
# Sample Watch FIFO

This block is a first-in first-out buffer that lets firmware look at the samples leaving the health-test stage of an entropy source. The hardware data path offers one 32-bit sample per cycle on a valid/data port. Firmware drains the buffer through a read port: each read strobe removes the oldest entry and returns it in the same cycle.

The block never stalls the producer. When the buffer is full, an offered sample is thrown away and a sticky overflow flag is raised. Firmware can therefore tell whether the samples it collected were contiguous. The flag is cleared only by a software write of zero.

The current fill level is reported on a depth output. A single-cycle ready event fires when the fill level first reaches a programmable threshold. Firmware normally programs that threshold to 32. A threshold of zero is reserved and never produces an event.

Top module: `sample_watch_fifo`

## Requirements
- R1: After reset, depth reads 0, the overflow flag is 0 and the ready event is low.
- R2: A read strobe returns entries in the order they were pushed, with all 32 bits intact.
- R3: The depth output is 7 bits wide. It counts stored entries from 0 to 64 and changes on the clock edge after the push or pop that caused the change.
- R4: A sample offered while the buffer holds 64 entries, with no read in the same cycle, is discarded and leaves the stored contents unchanged. The overflow flag reads 1 from the following cycle.
- R5: When a push and a read occur in the same cycle on a full buffer, the push is accepted, the depth stays at 64 and the overflow flag is not set.
- R6: The overflow flag stays set until a clear write that carries data bit 0. A clear write carrying 1 has no effect. If a drop happens in the same cycle as a clearing write, the flag stays set.
- R7: A read strobe on an empty buffer returns all zeros and drives the read-error output high for that cycle. The depth is unchanged.
- R8: The ready event is high for exactly one cycle: the first cycle in which depth is at least the threshold. It fires again only after depth falls below the threshold and then reaches it again.
- R9: A threshold of 0 never raises the ready event.
- R10: A push and a read in the same cycle on an empty buffer report a read error and return zero, and the pushed sample is stored.
- R11: Read data and read error are valid combinationally in the cycle of the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | A sample is offered this cycle |
| smp_data | input | 32 | Offered sample |
| rd_strobe | input | 1 | Firmware read: pop the oldest entry |
| rd_data | output | 32 | Popped entry, zero when empty |
| rd_err | output | 1 | Read attempted on an empty buffer |
| lvl_thresh | input | 7 | Fill level that triggers the ready event, 0 reserved |
| lvl_depth | output | 7 | Current number of stored entries |
| ovf_flag | output | 1 | Sticky flag: a sample was dropped |
| ovf_wr | input | 1 | Software write to the overflow flag |
| ovf_wdata | input | 1 | Value written; only 0 clears |
| lvl_event | output | 1 | One-cycle ready pulse |

## Verification
The bench drives the block into its edge cases:
- **Full-buffer swap.** A simultaneous push and read on a full buffer must keep the depth at 64 without flagging overflow. A design that tests fullness before the pop would drop the sample and falsely flag it.
- **Overflow-flag writes.** Clear writes carrying 1, and a clearing write in the same cycle as a drop, exercise the flag's priority. A wrong priority shows as a flag that clears while data is lost.
- **Empty-buffer reads.** Reads on an empty buffer, alone and together with a push, must return zero and flag an error. A design that bypasses the push into the read port would return the new sample instead.
- **Threshold crossings.** The bench crosses the threshold repeatedly, and also runs with a threshold of zero, to catch an event that is level-held, fires twice, or fires on the reserved value.

// File: rtl/obsf_pkg.sv
`timescale 1ns/1ps
package obsf_pkg;
   // Operation applied to the buffer on one clock edge
   typedef enum logic [1:0] {
      OBSF_HOLD = 2'b00,
      OBSF_ADD  = 2'b01,
      OBSF_TAKE = 2'b10,
      OBSF_SWAP = 2'b11
   } obsf_op_e;

   function automatic obsf_op_e obsf_op(input logic add, input logic take);
      return obsf_op_e'({take, add});
   endfunction
endpackage

// File: rtl/obsf_ptr_ctrl.sv
`timescale 1ns/1ps
module obsf_ptr_ctrl
   import obsf_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_vld,
   input  logic             pop_req,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             pop_ok,
   output logic             drop
);
   logic             full;
   logic [PTR_W-1:0] wr_nxt, rd_nxt;
   obsf_op_e         op;

   assign full   = (count == CNT_W'(DEPTH));
   assign empty  = (count == '0);
   assign pop_ok = pop_req && !empty;
   // a pop in the same cycle frees the slot the push needs
   assign wr_en  = push_vld && (!full || pop_ok);
   assign drop   = push_vld && full && !pop_ok;
   assign op     = obsf_op(wr_en, pop_ok);

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_mod
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en)  wr_ptr <= wr_nxt;
         if (pop_ok) rd_ptr <= rd_nxt;
         unique case (op)
            OBSF_ADD:  count <= count + 1'b1;
            OBSF_TAKE: count <= count - 1'b1;
            default:   count <= count;
         endcase
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R3
   AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> full); // R4
   AST_SWAP_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (push_vld && pop_req && full) |=> full); // R5
   AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && empty && !push_vld) |=> empty); // R7
endmodule

// File: rtl/obsf_store.sv
`timescale 1ns/1ps
module obsf_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [DATA_W-1:0] rd_word
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   assign rd_word = mem[rd_ptr];
endmodule

// File: rtl/obsf_ovf_flag.sv
`timescale 1ns/1ps
module obsf_ovf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic drop,
   input  logic clr_we,
   input  logic clr_bit,
   output logic ovf_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ovf_q <= 1'b0;
      else if (drop)              ovf_q <= 1'b1;
      else if (clr_we && !clr_bit) ovf_q <= 1'b0;
   end

   AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovf_q); // R4
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !(clr_we && !clr_bit)) |=> ovf_q); // R6
endmodule

// File: rtl/obsf_thresh_evt.sv
`timescale 1ns/1ps
module obsf_thresh_evt #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] thresh,
   output logic             evt
);
   logic at_level, above_q;

   assign at_level = (thresh != '0) && (count >= thresh);
   assign evt      = at_level && !above_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) above_q <= 1'b0;
      else        above_q <= at_level;
   end

   AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && $stable(count) && $stable(thresh)) |=> !evt); // R8
endmodule

// File: rtl/sample_watch_fifo.sv
`timescale 1ns/1ps
module sample_watch_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err,
   input  logic [CNT_W-1:0]  lvl_thresh,
   output logic [CNT_W-1:0]  lvl_depth,
   output logic              ovf_flag,
   input  logic              ovf_wr,
   input  logic              ovf_wdata,
   output logic              lvl_event
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sample_watch_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("sample_watch_fifo: DATA_W must be positive");
      end
   endgenerate

   logic             wr_en, empty, pop_ok, drop;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [DATA_W-1:0] head_word;

   obsf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .push_vld(smp_vld), .pop_req(rd_strobe),
      .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
      .count(lvl_depth), .empty(empty), .pop_ok(pop_ok), .drop(drop)
   );

   obsf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(smp_data),
      .rd_ptr(rd_ptr), .rd_word(head_word)
   );

   obsf_ovf_flag u_ovf (
      .clk(clk), .rst_n(rst_n), .drop(drop),
      .clr_we(ovf_wr), .clr_bit(ovf_wdata), .ovf_q(ovf_flag)
   );

   obsf_thresh_evt #(.CNT_W(CNT_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .count(lvl_depth),
      .thresh(lvl_thresh), .evt(lvl_event)
   );

   assign rd_data = pop_ok ? head_word : '0;
   assign rd_err  = rd_strobe && empty;

   AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> (rd_data == '0)); // R7
   AST_EMPTY_SWAP_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_err && smp_vld) |=> (lvl_depth == CNT_W'(1))); // R10
   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (lvl_depth == '0 && !ovf_flag)); // R1
endmodule

// File: tb/sim_sample_watch_fifo.sv
`timescale 1ns/1ps
module sim_sample_watch_fifo;
   localparam int DW = 32;
   localparam int DP = 64;
   localparam int CW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_vld = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic          rd_strobe = 1'b0;
   logic [DW-1:0] rd_data;
   logic          rd_err;
   logic [CW-1:0] lvl_thresh = CW'(32);
   logic [CW-1:0] lvl_depth;
   logic          ovf_flag;
   logic          ovf_wr = 1'b0;
   logic          ovf_wdata = 1'b0;
   logic          lvl_event;

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";

   // reference model state
   logic [DW-1:0] q[$];
   bit m_ovf = 0;
   bit m_above = 0;
   int seq = 0;

   always #2 clk = ~clk;

   sample_watch_fifo u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_err(rd_err),
      .lvl_thresh(lvl_thresh), .lvl_depth(lvl_depth), .ovf_flag(ovf_flag),
      .ovf_wr(ovf_wr), .ovf_wdata(ovf_wdata), .lvl_event(lvl_event)
   );

   task automatic check_eq(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                           input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   // one clock: drive, compare against model, advance model
   task automatic cyc(input bit pv, input bit pr, input bit cw, input bit cb);
      int sz;
      bit pop_ok, drop, at_lvl;
      logic [DW-1:0] d;
      @(negedge clk);
      seq++;
      d = 32'hC3A5_0000 ^ (seq * 32'h0001_0F1D);
      smp_vld = pv; smp_data = d; rd_strobe = pr;
      ovf_wr = cw; ovf_wdata = cb;
      #1;
      sz = q.size();
      at_lvl = (lvl_thresh != 0) && (sz >= int'(lvl_thresh));
      check_eq(DW'(lvl_depth), DW'(sz), "depth");
      check_eq(DW'(ovf_flag), DW'(m_ovf), "ovf_flag");
      check_eq(DW'(lvl_event), DW'(at_lvl && !m_above), "lvl_event");
      check_eq(DW'(rd_err), DW'(pr && sz == 0), "rd_err");
      check_eq(rd_data, (pr && sz > 0) ? q[0] : '0, "rd_data");
      pop_ok = pr && sz > 0;
      drop = pv && sz == DP && !pop_ok;
      m_above = at_lvl;
      if (pop_ok) void'(q.pop_front());
      if (pv && !drop) q.push_back(d);
      if (drop) m_ovf = 1;
      else if (cw && !cb) m_ovf = 0;
   endtask

   initial begin
      #(4 * 20000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      cur_req = "R1";
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
      // R2, R3, R11: push five, pop them back in order
      cur_req = "R2";
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
      cur_req = "R11";
      for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0);
      // R8: fill to full with threshold 32, event on crossing
      cur_req = "R8";
      for (int i = 0; i < 64; i++) cyc(1, 0, 0, 0);
      cur_req = "R3";
      cyc(0, 0, 0, 0);
      // R4: drops on full
      cur_req = "R4";
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
      // R6: clear write with 1 is ignored, write 0 clears
      cur_req = "R6";
      cyc(0, 0, 1, 1);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 0);
      // R5: swap on full, no overflow
      cur_req = "R5";
      for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0);
      // R6: drop and clear together, flag stays set
      cur_req = "R6";
      cyc(1, 0, 1, 0);
      cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 0);
      // R2: drain everything and verify order
      cur_req = "R2";
      for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0);
      // R7: read on empty
      cur_req = "R7";
      cyc(0, 1, 0, 0);
      cyc(0, 1, 0, 0);
      // R10: push and read together on empty
      cur_req = "R10";
      cyc(1, 1, 0, 0);
      cyc(0, 1, 0, 0);
      // R9: threshold zero never fires
      cur_req = "R9";
      lvl_thresh = '0;
      for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
      for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0);
      // R8: threshold 3, cross, fall back, cross again
      cur_req = "R8";
      lvl_thresh = CW'(3);
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
      for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0);
      for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule